// File: doc/BRIEF.md
# Run-Time Programmable Sum-of-Products Array

This block is a two-plane logic array whose connections are set at run time. Each product term has an AND-plane row and an OR-plane row. The AND-plane row picks which true and which complemented input literals the term multiplies together. The OR-plane row picks which outputs that term drives. Once every row the application needs has been written, each output is the OR of the product terms routed to it. The outputs are evaluated combinationally from the live inputs, with no clock latency. Any product term can feed any number of outputs, so a term needed by several functions is built only once.

Configuration is written one term row per clock cycle. Each write carries a row address, the AND-plane word and the OR-plane word for that term. A write to the last row marks the array as ready. A write to any other row marks it as loading. While the array is loading, every output is held at 0, so a partly loaded array never drives a half-built function. By default the array has 16 inputs, 32 product terms and 8 outputs.

Top module: `pla_core`

## Requirements
- R1: A reset sets every AND-plane and OR-plane row to all zeros and clears `cfg_done`. After a reset, `f_out` is 0.
- R2: A cycle with `cfg_we` high stores `cfg_and` and `cfg_or` as row `cfg_addr`, replacing what that row held. The new row takes effect from the next clock edge.
- R3: A write to row N_TERM-1 sets `cfg_done` from the next edge. A write to any other row clears it from the next edge. Without a write, `cfg_done` holds its value.
- R4: While `cfg_done` is 0, `f_out` is all zeros whatever the inputs and planes hold.
- R5: In an AND-plane word, bit i connects input i in true form and bit N_IN+i connects input i in complemented form. A term is the AND of all the literals it connects.
- R6: A product term with no literal connected evaluates to 0.
- R7: A product term that connects both the true and the complemented form of the same input evaluates to 0.
- R8: Bit o of an OR-plane word routes that term to output o. Output o is the OR of all terms routed to it, and one term may be routed to several outputs.
- R9: An output that no term is routed to stays at 0.
- R10: Once configured, `f_out` follows a change of `x_in` within the same cycle, with no clock edge needed.
- R11: Four product terms with three inputs realise x0x1 + x0x2' + x0'x1'x2 on output 0 and x0x1 + x0'x1'x2 + x0x2 on output 1. Two of the terms are shared by both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Row write strobe |
| cfg_addr | input | $clog2(N_TERM) | Product-term row being written |
| cfg_and | input | 2*N_IN | AND-plane literal connections for the row |
| cfg_or | input | N_OUT | OR-plane output connections for the row |
| x_in | input | N_IN | Live logic inputs |
| f_out | output | N_OUT | Sum-of-products outputs |
| cfg_done | output | 1 | Array is configured and outputs are valid |

## Verification
The assertions check four things on every cycle:
- the ready-flag sequencing on writes and idle cycles;
- the forcing of the outputs to zero while the array is loading;
- the cleared state after reset;
- that the outputs do not move when neither a write nor an input change has happened.

Only the bench's scenarios can show what the logic produces:
- the example functions over all eight input patterns;
- empty and contradictory terms;
- a term shared by several outputs;
- rewriting a row;
- a reset that wipes the planes.

// File: rtl/pla_pkg.sv
package pla_pkg;
    // Default array dimensions
    localparam int DEF_INPUTS  = 16;
    localparam int DEF_TERMS   = 32;
    localparam int DEF_OUTPUTS = 8;

    // Load state of the array
    typedef enum logic {
        ARR_LOADING = 1'b0,
        ARR_READY   = 1'b1
    } arr_state_e;
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
    import pla_pkg::*;
#(
    parameter int N_IN   = DEF_INPUTS,
    parameter int N_TERM = DEF_TERMS,
    parameter int N_OUT  = DEF_OUTPUTS
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [$clog2(N_TERM)-1:0]        wr_row,
    input  logic [2*N_IN-1:0]                wr_and,
    input  logic [N_OUT-1:0]                 wr_or,
    output logic [N_TERM-1:0][2*N_IN-1:0]    and_rows,
    output logic [N_TERM-1:0][N_OUT-1:0]     or_rows,
    output logic                             ready
);
    localparam int LW = 2 * N_IN;
    localparam int AW = $clog2(N_TERM);
    localparam logic [AW-1:0] LAST_ROW = AW'(N_TERM - 1);

    typedef struct packed {
        logic [N_TERM-1:0][LW-1:0]    and_pl;
        logic [N_TERM-1:0][N_OUT-1:0] or_pl;
        arr_state_e                   st;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (int'(wr_row) < N_TERM)) begin
            st_d.and_pl[wr_row] = wr_and;
            st_d.or_pl[wr_row]  = wr_or;
            st_d.st = (wr_row == LAST_ROW) ? ARR_READY : ARR_LOADING;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign and_rows = st_q.and_pl;
    assign or_rows  = st_q.or_pl;
    assign ready    = (st_q.st == ARR_READY);
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN   = pla_pkg::DEF_INPUTS,
    parameter int N_TERM = pla_pkg::DEF_TERMS
) (
    input  logic [N_IN-1:0]                  x_in,
    input  logic [N_TERM-1:0][2*N_IN-1:0]    and_rows,
    output logic [N_TERM-1:0]                term
);
    localparam int LW = 2 * N_IN;

    // Low half: true literals, high half: complemented literals
    logic [LW-1:0] lits;
    assign lits = {~x_in, x_in};

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        // An empty row yields 0; a contradictory row never has all literals true
        assign term[t] = (|and_rows[t]) & (&(~and_rows[t] | lits));
    end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_TERM = pla_pkg::DEF_TERMS,
    parameter int N_OUT  = pla_pkg::DEF_OUTPUTS
) (
    input  logic [N_TERM-1:0]                term,
    input  logic [N_TERM-1:0][N_OUT-1:0]     or_rows,
    input  logic                             ready,
    output logic [N_OUT-1:0]                 f
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [N_TERM-1:0] col;
        always_comb begin
            for (int t = 0; t < N_TERM; t++) begin
                col[t] = or_rows[t][o];
            end
        end
        assign f[o] = ready & (|(col & term));
    end
endmodule

// File: rtl/pla_core.sv
module pla_core #(
    parameter int N_IN   = pla_pkg::DEF_INPUTS,
    parameter int N_TERM = pla_pkg::DEF_TERMS,
    parameter int N_OUT  = pla_pkg::DEF_OUTPUTS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [$clog2(N_TERM)-1:0]  cfg_addr,
    input  logic [2*N_IN-1:0]          cfg_and,
    input  logic [N_OUT-1:0]           cfg_or,
    input  logic [N_IN-1:0]            x_in,
    output logic [N_OUT-1:0]           f_out,
    output logic                       cfg_done
);
    localparam int LW = 2 * N_IN;

    logic [N_TERM-1:0][LW-1:0]    and_rows;
    logic [N_TERM-1:0][N_OUT-1:0] or_rows;
    logic [N_TERM-1:0]            term;
    logic                         ready;

    pla_cfg_store #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_row   (cfg_addr),
        .wr_and   (cfg_and),
        .wr_or    (cfg_or),
        .and_rows (and_rows),
        .or_rows  (or_rows),
        .ready    (ready)
    );

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .x_in     (x_in),
        .and_rows (and_rows),
        .term     (term)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .term    (term),
        .or_rows (or_rows),
        .ready   (ready),
        .f       (f_out)
    );

    assign cfg_done = ready;
endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk #(
    parameter int N_IN   = pla_pkg::DEF_INPUTS,
    parameter int N_TERM = pla_pkg::DEF_TERMS,
    parameter int N_OUT  = pla_pkg::DEF_OUTPUTS
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_we,
    input logic [$clog2(N_TERM)-1:0]  cfg_addr,
    input logic [N_IN-1:0]            x_in,
    input logic [N_OUT-1:0]           f_out,
    input logic                       cfg_done
);
    localparam int AW = $clog2(N_TERM);
    localparam logic [AW-1:0] LAST_ROW = AW'(N_TERM - 1);

    // R1: first cycle out of reset shows a cleared array
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cfg_done && f_out == '0));

    // R3: writing the last row marks the array ready
    p_done_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == LAST_ROW) |=> cfg_done);

    // R3: writing any other row marks it loading
    p_done_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr != LAST_ROW) |=> !cfg_done);

    // R3: no write, flag holds
    p_done_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && $past(rst_n)) |=> $stable(cfg_done));

    // R4: outputs forced low while loading
    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> (f_out == '0));

    // R10: outputs depend only on stored planes and live inputs
    p_comb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_we) && $stable(x_in)) |-> $stable(f_out));
endmodule

bind pla_core pla_core_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .x_in     (x_in),
    .f_out    (f_out),
    .cfg_done (cfg_done)
);

// File: tb/sim_pla_core.sv
module sim_pla_core;
    localparam int N_IN   = 16;
    localparam int N_TERM = 32;
    localparam int N_OUT  = 8;
    localparam int AW     = $clog2(N_TERM);

    // {x[2:0], expected f_out} for the three-input example
    localparam logic [10:0] VEC [0:7] = '{
        {3'd0, 8'h00}, {3'd1, 8'h01}, {3'd2, 8'h00}, {3'd3, 8'h03},
        {3'd4, 8'h03}, {3'd5, 8'h02}, {3'd6, 8'h00}, {3'd7, 8'h03}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [AW-1:0]     cfg_addr = '0;
    logic [2*N_IN-1:0] cfg_and = '0;
    logic [N_OUT-1:0]  cfg_or = '0;
    logic [N_IN-1:0]   x_in = '0;
    logic [N_OUT-1:0]  f_out;
    logic              cfg_done;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pla_core #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_and(cfg_and), .cfg_or(cfg_or), .x_in(x_in),
        .f_out(f_out), .cfg_done(cfg_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int row, input logic [2*N_IN-1:0] a, input logic [N_OUT-1:0] o);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(row); cfg_and = a; cfg_or = o;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_x(input logic [N_IN-1:0] v);
        x_in = v;
        #1;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        set_x(16'hFFFF);
        check("R1 done after reset", 32'(cfg_done), 32'd0);
        check("R1 f after reset", 32'(f_out), 32'd0);

        // Example: P1=x0x1, P2=x0x2', P3=x0'x1'x2, P4=x0x2
        wr(0, 32'h0000_0003, 8'h03);
        wr(1, 32'h0004_0001, 8'h01);
        wr(2, 32'h0003_0004, 8'h03);
        wr(3, 32'h0000_0005, 8'h02);
        set_x(16'h0003);
        check("R4 gated while loading", 32'(f_out), 32'd0);
        check("R3 not ready before last row", 32'(cfg_done), 32'd0);
        wr(N_TERM - 1, '0, '0);
        check("R3 ready after last row", 32'(cfg_done), 32'd1);

        for (int i = 0; i < 8; i++) begin
            set_x(N_IN'(VEC[i][10:8]));
            check("R11 R5 R8 R9 example", 32'(f_out), 32'(VEC[i][7:0]));
        end

        // R10: change inputs mid-cycle, no edge in between
        @(posedge clk); #1;
        set_x(16'h0004);
        check("R10 combinational follow", 32'(f_out), 32'h03);
        set_x(16'h0005);
        check("R10 combinational follow 2", 32'(f_out), 32'h02);

        // R6: empty term routed to output 2
        wr(4, 32'h0, 8'h04);
        check("R3 cleared by other row", 32'(cfg_done), 32'd0);
        wr(N_TERM - 1, '0, '0);
        set_x(16'h0000);
        check("R6 empty term x=0", 32'(f_out & 8'h04), 32'h0);
        set_x(16'hFFFF);
        check("R6 empty term x=all1", 32'(f_out & 8'h04), 32'h0);

        // R7: contradictory term x0 & ~x0 routed to output 3
        wr(5, 32'h0001_0001, 8'h08);
        wr(N_TERM - 1, '0, '0);
        set_x(16'h0001);
        check("R7 contradictory x0=1", 32'(f_out & 8'h08), 32'h0);
        set_x(16'h0000);
        check("R7 contradictory x0=0", 32'(f_out & 8'h08), 32'h0);

        // R8: one term shared by outputs 4 and 5
        wr(6, 32'h0000_0020, 8'h30);
        wr(N_TERM - 1, '0, '0);
        set_x(16'h0020);
        check("R8 shared term", 32'(f_out), 32'h30);

        // R3: flag holds across idle cycles
        repeat (4) @(negedge clk);
        check("R3 hold when idle", 32'(cfg_done), 32'd1);

        // R2: overwrite row 6
        wr(6, 32'h0000_0020, 8'h40);
        wr(N_TERM - 1, '0, '0);
        set_x(16'h0020);
        check("R2 row overwrite", 32'(f_out), 32'h40);

        // R1: reset mid-run wipes both planes
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 done after second reset", 32'(cfg_done), 32'd0);
        check("R1 f after second reset", 32'(f_out), 32'd0);
        wr(N_TERM - 1, '0, '0);
        set_x(16'h0023);
        check("R1 planes cleared", 32'(f_out), 32'd0);
        set_x(16'h0003);
        check("R9 unrouted outputs zero", 32'(f_out), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule